// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Registers

This block holds the interrupt state of a USB host controller. Internal logic raises one-cycle event pulses. Each pulse is captured into a sticky pending bit that stays set until software clears it. A separate mask selects which pending bits may reach the processor. One top mask bit acts as a global gate over all sources. The single `irq` output is high whenever that gate is open and at least one unmasked pending bit is set.

Software uses a plain word-addressed register port with address, write data, a write strobe and combinational read data. Three consecutive word addresses are decoded:

- **Pending word (word `STATUS_WORD`):** writing ones clears the matching pending bits.
- **Mask-set word (`STATUS_WORD+1`):** writing ones turns the matching mask bits on.
- **Mask-clear word (`STATUS_WORD+2`):** writing ones turns the matching mask bits off.

Both mask words read back the same current mask. Software can therefore change single mask bits without a read-modify-write sequence.

Top module: `hc_irq_regs`

## Requirements
- R1: After reset, the pending word and the mask read as 0 and `irq` is 0.
- R2: A pulse on `evtPulse[i]` sets pending bit i at the next rising clock edge, and the bit stays set after the pulse ends. The implemented sources are bit 0 (schedule overrun), bit 1 (done queue written back), bit 2 (frame start), bit 3 (resume seen), bit 4 (fatal error), bit 5 (frame counter wrap), bit 6 (hub port change) and bit 30 (ownership handover).
- R3: Writing to word `STATUS_WORD` clears every pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Writing to word `STATUS_WORD+1` sets every mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Writing to word `STATUS_WORD+2` clears every mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: Reads of word `STATUS_WORD+1` and of word `STATUS_WORD+2` both return the current mask.
- R7: Bits that are not implemented read as 0 and ignore writes and pulses. The pending word implements bits 0..6 and 30. The mask implements bits 0..6, 30 and 31.
- R8: `irq` is 1 exactly when mask bit 31 is 1 and, for some bit i in 0..30, both pending bit i and mask bit i are 1.
- R9: If a pulse on bit i and a clearing write of bit i arrive in the same cycle, pending bit i ends up set.
- R10: A read of any other word address returns 0, and a write to any other word address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address of the access |
| wrEn | input | 1 | Write strobe; the write takes effect at the next rising edge |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, combinational |
| evtPulse | input | DATA_W-1 | Event pulses, one per bit position 0..30 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters:

- `DATA_W` 32, so bit 31 is the global gate and bits 0..30 are the source positions.
- `ADDR_W` 4 with `STATUS_WORD` 0, which leaves word addresses 3..15 free. Word 3 serves as the unmapped address for the R10 checks.
- The default source mask, so every implemented source and every unimplemented gap in the words can be driven. This lets all-ones writes and all-ones pulses show which bits are live.

The event-versus-clear collision is driven on an implemented bit. In the same cycle, a clear of a different bit shows that the clear is still applied to the other bits.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

  // Which register the read mux returns
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2
  } rdSel_e;

  // Strobes from address decode to the register datapath
  typedef struct packed {
    logic   statusClr;
    logic   enSet;
    logic   enClr;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/hc_irq_ctrl.sv
module hc_irq_ctrl
  import hc_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_WORD = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] StAddr  = ADDR_W'(STATUS_WORD);
  localparam logic [ADDR_W-1:0] SetAddr = ADDR_W'(STATUS_WORD + 1);
  localparam logic [ADDR_W-1:0] ClrAddr = ADDR_W'(STATUS_WORD + 2);

  logic hitStatus;
  logic hitSet;
  logic hitClr;

  always_comb begin
    hitStatus = (addr == StAddr);
    hitSet    = (addr == SetAddr);
    hitClr    = (addr == ClrAddr);

    strobe.statusClr = wrEn & hitStatus;
    strobe.enSet     = wrEn & hitSet;
    strobe.enClr     = wrEn & hitClr;

    if (hitStatus)            strobe.rdSel = SEL_STATUS;
    else if (hitSet | hitClr) strobe.rdSel = SEL_ENABLE;
    else                      strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/hc_irq_datapath.sv
module hc_irq_datapath
  import hc_irq_pkg::*;
#(
  parameter int                  DATA_W   = 32,
  parameter logic [DATA_W-2:0]   SRC_MASK = 31'h4000_007F
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-2:0] evtPulse,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] enableQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int SRC_N  = DATA_W - 1;
  localparam int MASTER = DATA_W - 1;

  logic [SRC_N-1:0] pendVec;

  // Pending bits: the event has priority over a same-cycle clear
  for (genvar i = 0; i < SRC_N; i++) begin : g_status
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= SRC_MASK[i] &
                               (evtPulse[i] | (statusQ[i] & ~(strobe.statusClr & wrData[i])));
    end
  end
  assign statusQ[MASTER] = 1'b0;

  // Mask bits: set and clear arrive on separate addresses
  for (genvar i = 0; i < DATA_W; i++) begin : g_enable
    localparam logic Impl = (i == MASTER) ? 1'b1 : SRC_MASK[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) enableQ[i] <= 1'b0;
      else       enableQ[i] <= Impl &
                               ((enableQ[i] | (strobe.enSet & wrData[i])) &
                                ~(strobe.enClr & wrData[i]));
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_STATUS: rdData = statusQ;
      SEL_ENABLE: rdData = enableQ;
      default:    rdData = '0;
    endcase
  end

  assign pendVec = statusQ[SRC_N-1:0] & enableQ[SRC_N-1:0];
  assign irq     = enableQ[MASTER] & (|pendVec);

endmodule

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
  import hc_irq_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                STATUS_WORD = 0,
  parameter int                DATA_W      = 32,
  parameter logic [DATA_W-2:0] SRC_MASK    = 31'h4000_007F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-2:0] evtPulse,
  output logic              irq
);

  regStrobe_t        strobe;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] enableQ;

  hc_irq_ctrl #(
    .ADDR_W      (ADDR_W),
    .STATUS_WORD (STATUS_WORD)
  ) u_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .strobe (strobe)
  );

  hc_irq_datapath #(
    .DATA_W   (DATA_W),
    .SRC_MASK (SRC_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .evtPulse (evtPulse),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .rdData   (rdData),
    .irq      (irq)
  );

endmodule

// File: rtl/hc_irq_regs_chk.sv
module hc_irq_regs_chk #(
  parameter int                ADDR_W      = 4,
  parameter int                STATUS_WORD = 0,
  parameter int                DATA_W      = 32,
  parameter logic [DATA_W-2:0] SRC_MASK    = 31'h4000_007F
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-2:0] evtPulse,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] enableQ,
  input logic              irq
);

  localparam logic [ADDR_W-1:0] StA  = ADDR_W'(STATUS_WORD);
  localparam logic [ADDR_W-1:0] SetA = ADDR_W'(STATUS_WORD + 1);
  localparam logic [ADDR_W-1:0] ClrA = ADDR_W'(STATUS_WORD + 2);
  localparam logic [DATA_W-1:0] StM  = {1'b0, SRC_MASK};
  localparam logic [DATA_W-1:0] EnM  = {1'b1, SRC_MASK};

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & SRC_MASK) != '0) |=>
      ((statusQ[DATA_W-2:0] & $past(evtPulse & SRC_MASK)) == $past(evtPulse & SRC_MASK))); // R2

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse == '0 && !(wrEn && addr == StA)) |=> $stable(statusQ)); // R3

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == SetA) |=>
      ((enableQ & $past(wrData & EnM)) == $past(wrData & EnM))); // R4

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ClrA) |=> ((enableQ & $past(wrData)) == '0)); // R5

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~StM) == '0) && ((enableQ & ~EnM) == '0)); // R7

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ[DATA_W-1] |-> !irq); // R8

  AST_NO_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & enableQ) == '0) |-> !irq); // R8

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != StA && addr != SetA && addr != ClrA) |=> $stable(enableQ)); // R10

endmodule

bind hc_irq_regs hc_irq_regs_chk #(
  .ADDR_W      (ADDR_W),
  .STATUS_WORD (STATUS_WORD),
  .DATA_W      (DATA_W),
  .SRC_MASK    (SRC_MASK)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .evtPulse (evtPulse),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .irq      (irq)
);

// File: tb/hc_irq_regs_bench.sv
`timescale 1ns/1ps
module hc_irq_regs_bench;

  localparam logic [3:0] ST  = 4'd0;
  localparam logic [3:0] SET = 4'd1;
  localparam logic [3:0] CLR = 4'd2;
  localparam logic [3:0] UNM = 4'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [30:0] evtPulse = '0;
  logic        irq;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  hc_irq_regs u_hc_irq_regs (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .evtPulse (evtPulse),
    .irq      (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic pulse(input logic [30:0] e, input logic doClr, input logic [31:0] clrD);
    @(negedge clk);
    evtPulse = e;
    if (doClr) begin addr = ST; wrData = clrD; wrEn = 1'b1; end
    @(negedge clk);
    evtPulse = '0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(ST, v);  chk("R1 pending after reset", v, 32'h0);
    rd(SET, v); chk("R1 mask after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_event();
    logic [31:0] v;
    pulse(31'h4000_0041, 1'b0, '0);
    rd(ST, v); chk("R2 pending after pulses", v, 32'h4000_0041);
    repeat (3) @(negedge clk);
    rd(ST, v); chk("R2 pending sticky", v, 32'h4000_0041);
    chk("R8 irq low with empty mask", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(ST, 32'h0000_0001);
    rd(ST, v); chk("R3 clear bit 0", v, 32'h4000_0040);
    wr(ST, 32'h0);
    rd(ST, v); chk("R3 zero write keeps bits", v, 32'h4000_0040);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(SET, 32'h8000_0040);
    rd(SET, v); chk("R4 mask set", v, 32'h8000_0040);
    rd(CLR, v); chk("R6 clear word reads mask", v, 32'h8000_0040);
    chk("R8 irq with gate and pending", {31'b0, irq}, 32'h1);
    wr(SET, 32'h0);
    rd(SET, v); chk("R4 zero write keeps mask", v, 32'h8000_0040);
    wr(CLR, 32'h8000_0000);
    rd(SET, v); chk("R5 gate cleared", v, 32'h0000_0040);
    chk("R8 irq low with gate off", {31'b0, irq}, 32'h0);
    wr(CLR, 32'h0);
    rd(CLR, v); chk("R5 zero write keeps mask", v, 32'h0000_0040);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(SET, 32'hFFFF_FFFF);
    rd(SET, v); chk("R7 mask live bits", v, 32'hC000_007F);
    pulse(31'h7FFF_FFFF, 1'b0, '0);
    rd(ST, v); chk("R7 pending live bits", v, 32'h4000_007F);
    wr(ST, 32'hFFFF_FFFF);
    rd(ST, v); chk("R3 clear all", v, 32'h0);
    chk("R8 irq low with nothing pending", {31'b0, irq}, 32'h0);
    wr(CLR, 32'h7FFF_FFBF);
    rd(SET, v); chk("R5 clear leaves bits 31 and 6", v, 32'h8000_0040);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(31'h0000_0010, 1'b0, '0);
    pulse(31'h0000_0004, 1'b1, 32'h0000_0014);
    rd(ST, v); chk("R9 event beats clear", v, 32'h0000_0004);
    pulse(31'h0000_0040, 1'b0, '0);
    chk("R8 irq on masked source", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(UNM, 32'hFFFF_FFFF);
    rd(SET, v); chk("R10 mask unchanged", v, 32'h8000_0040);
    rd(ST, v);  chk("R10 pending unchanged", v, 32'h0000_0044);
    rd(UNM, v); chk("R10 unmapped read zero", v, 32'h0);
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_event();
    t_w1c();
    t_enable();
    t_unimpl();
    t_collide();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule